// File: doc/BRIEF.md
# Prefix-Tree Adder with Folded Carry-In

This block adds two unsigned operands and a single carry-in without any clock. It is a parallel prefix network of three stages: per-bit propagate and generate, a sparse tree that builds the group generate of every prefix that ends at the lowest position, and a row of XOR gates that forms the sum. The carry-in sits in the tree as an extra lowest position. Its generate is the carry-in and its propagate is tied to zero, so the tree carries it to every bit without a separate increment path.

The tree does not use a full logarithmic network. The two most significant data bits are first merged into one pair term with a black cell. That pair is then joined once with the prefix of everything below it, which includes the carry-in, to form the carry-out. Lower prefixes are built with gray cells only, because no propagate term is consumed above them. The width is a parameter, so the block can serve as the fast section of a wider carry-select adder.

Top module: `pfx_add`

## Requirements
- R1: For every combination of `a_i`, `b_i` and `cin_i`, the concatenation `{cout_o, sum_o}` equals the unsigned value a + b + cin.
- R2: When no bit position has both operand bits set and `cin_i` is 0, `sum_o` equals `a_i ^ b_i` and `cout_o` is 0.
- R3: When every bit position has exactly one operand bit set, the carry-in passes the whole chain: `cout_o` equals `cin_i`, and `sum_o` is all ones for `cin_i` = 0 and all zeros for `cin_i` = 1.
- R4: When both operand bits of the most significant position are 1, `cout_o` is 1 whatever the lower bits and the carry-in are.
- R5: When the most significant position propagates (its operand bits differ) and the position below it has both operand bits set, `cout_o` is 1.
- R6: When both operand bits of the most significant position are 0, `cout_o` is 0.
- R7: Bit 0 of the sum is the XOR of `a_i[0]`, `b_i[0]` and `cin_i`.
- R8: The same rules hold for a width other than the default of 4 (checked at width 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into the least significant bit |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
All 512 input combinations of the 4-bit adder are applied, which settles the arithmetic for every operand pair at both carry-in values. Directed groups then isolate the tree paths. Operands with no shared set bits exercise the generate-free case. Complementary operands force a full propagate chain, so only the folded carry-in can set the carry-out. Vectors with the top pair set, or with the top bit propagating and the next bit generating, separate the pair cell from the final join. An 8-bit instance gets random and directed vectors to show that the reduced tree still reaches every sum bit when the gray-cell chain is longer.

// File: rtl/pfx_add.sv
module pfx_add #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int TOP = WIDTH;
  localparam int NXT = WIDTH - 1;

  function automatic logic gray_cell(input logic g_hi, input logic p_hi, input logic g_lo);
    return g_hi | (p_hi & g_lo);
  endfunction

  // Position 0 holds the carry-in; data bit k lives at position k+1.
  logic [TOP:0]   pos_p;
  logic [TOP:0]   pos_g;
  logic [NXT:0]   pre_g;
  logic           pair_g;
  logic           pair_p;

  assign pos_p = {a_i ^ b_i, 1'b0};
  assign pos_g = {a_i & b_i, cin_i};

  // buffer cell
  assign pre_g[0] = pos_g[0];

  genvar i;
  generate
    for (i = 1; i < NXT; i++) begin : g_low
      assign pre_g[i] = gray_cell(pos_g[i], pos_p[i], pre_g[i-1]);
    end
  endgenerate

  // black cell: merge the two top positions
  assign pair_g = gray_cell(pos_g[TOP], pos_p[TOP], pos_g[NXT]);
  assign pair_p = pos_p[TOP] & pos_p[NXT];

  assign pre_g[NXT] = gray_cell(pos_g[NXT], pos_p[NXT], pre_g[NXT-1]);
  assign cout_o     = gray_cell(pair_g, pair_p, pre_g[NXT-1]);

  assign sum_o = pos_p[TOP:1] ^ pre_g;
endmodule

// File: rtl/pfx_add_chk.sv
module pfx_add_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);
  logic [WIDTH:0] total;
  assign total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i, sum_o, cout_o})) begin
      assert_total_R1: assert ({cout_o, sum_o} == total);
      assert_top_gen_R4: assert (!(a_i[WIDTH-1] & b_i[WIDTH-1]) || cout_o);
      assert_pair_R5: assert (!((a_i[WIDTH-1] ^ b_i[WIDTH-1]) & a_i[WIDTH-2] & b_i[WIDTH-2]) || cout_o);
      assert_top_kill_R6: assert ((a_i[WIDTH-1] | b_i[WIDTH-1]) || !cout_o);
      assert_bit0_R7: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i));
      assert_chain_R3: assert (!(&(a_i ^ b_i)) || (cout_o == cin_i));
    end
  end
endmodule

bind pfx_add pfx_add_chk #(.WIDTH(WIDTH)) u_pfx_add_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o)
);

// File: tb/test_pfx_add.sv
module test_pfx_add;
  localparam int W4 = 4;
  localparam int W8 = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W4-1:0] a4, b4, s4;
  logic          c4, co4;
  logic [W8-1:0] a8, b8, s8;
  logic          c8, co8;

  pfx_add #(.WIDTH(W4)) i_pfx_add (
    .a_i(a4), .b_i(b4), .cin_i(c4), .sum_o(s4), .cout_o(co4));
  pfx_add #(.WIDTH(W8)) i_pfx_add_w8 (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8));

  int checks = 0;
  int failures = 0;

  logic [W4:0] q4[$];
  string       t4[$];
  logic [W8:0] q8[$];
  string       t8[$];

  task automatic drive4(input logic [W4-1:0] a, input logic [W4-1:0] b, input logic c, input string tag);
    @(posedge clk);
    #2;
    a4 = a; b4 = b; c4 = c;
    q4.push_back({1'b0, a} + {1'b0, b} + {{W4{1'b0}}, c});
    t4.push_back(tag);
  endtask

  task automatic drive8(input logic [W8-1:0] a, input logic [W8-1:0] b, input logic c, input string tag);
    @(posedge clk);
    #2;
    a8 = a; b8 = b; c8 = c;
    q8.push_back({1'b0, a} + {1'b0, b} + {{W8{1'b0}}, c});
    t8.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (q4.size() > 0) begin
      logic [W4:0] e;
      string tg;
      e = q4.pop_front();
      tg = t4.pop_front();
      checks++;
      if ({co4, s4} !== e) begin
        failures++;
        $display("FAIL %s w4 a=%h b=%h cin=%b actual=%h expected=%h", tg, a4, b4, c4, {co4, s4}, e);
      end
    end
    if (q8.size() > 0) begin
      logic [W8:0] e;
      string tg;
      e = q8.pop_front();
      tg = t8.pop_front();
      checks++;
      if ({co8, s8} !== e) begin
        failures++;
        $display("FAIL %s w8 a=%h b=%h cin=%b actual=%h expected=%h", tg, a8, b8, c8, {co8, s8}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    a4 = '0; b4 = '0; c4 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    // idle state: zero inputs give zero outputs (R1)
    drive4('0, '0, 1'b0, "R1");
    drive8('0, '0, 1'b0, "R8");
    // R1: exhaustive
    for (int n = 0; n < 512; n++)
      drive4(n[3:0], n[7:4], n[8], "R1");
    // R2: no shared set bits, cin 0
    for (int n = 0; n < 16; n++)
      drive4(n[3:0], ~n[3:0] & 4'h5, 1'b0, "R2");
    // R3: full propagate chain
    for (int n = 0; n < 16; n++) begin
      drive4(n[3:0], ~n[3:0], 1'b0, "R3");
      drive4(n[3:0], ~n[3:0], 1'b1, "R3");
    end
    // R4: top pair generate
    for (int n = 0; n < 16; n++)
      drive4({1'b1, n[2:0]}, {1'b1, ~n[2:0]}, n[3], "R4");
    // R5: top propagates, next generates
    drive4(4'b1100, 4'b0100, 1'b0, "R5");
    drive4(4'b0100, 4'b1100, 1'b1, "R5");
    // R6: top kills
    drive4(4'b0111, 4'b0111, 1'b1, "R6");
    drive4(4'b0000, 4'b0111, 1'b1, "R6");
    // R7: bit 0 with carry-in
    drive4(4'b0001, 4'b0000, 1'b1, "R7");
    drive4(4'b0000, 4'b0000, 1'b1, "R7");
    // R8: wider instance
    for (int n = 0; n < 3000; n++)
      drive8(W8'($urandom), W8'($urandom), 1'($urandom), "R8");
    drive8(8'hFF, 8'h00, 1'b1, "R8");
    drive8(8'hAA, 8'h55, 1'b0, "R8");
    drive8(8'h80, 8'h80, 1'b0, "R8");
    drive8(8'h40, 8'hC0, 1'b0, "R8");
    drive8(8'hFF, 8'hFF, 1'b1, "R8");
    @(posedge clk);
    @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule